// File: doc/BRIEF.md
# Tag-Renaming Issue Stage with Reservation Stations

This block is the issue and wait stage for one functional unit in a dynamically scheduled core. One instruction at the head of a fetch-ordered queue is offered each cycle. It is accepted into a reservation station only when one of the unit's stations is free. Each source register is read through a register status table. If no instruction in flight will write that register, the current register-file value is copied into the station. Otherwise the station records the tag (index) of the station that will produce it. The destination register is then renamed to the accepting station, so later readers wait on that station and not on the register name.

A station starts executing as soon as both of its operands hold values. The unit is modelled as a fixed-latency stub that adds or subtracts. A finished station puts its result on a single shared result bus. Every waiting station whose tag matches picks the value up in that cycle. The register file is written only when its status entry still names the broadcasting station. A small read port lets the surrounding logic, or a test, observe any register value and whether a result for it is still pending.

Top module: `renameIssue`

## Requirements
- R1: After reset every station is free (`inReady` high), no result is broadcast, every register `r` holds the value `r`, and no register is pending.
- R2: The offered instruction is taken at a rising edge only if `inValid` is high and some station is free. It goes to the lowest-numbered free station, whose index is shown on `issueTag` during the accepting cycle. With every station busy, `inReady` is low and the instruction waits unchanged.
- R3: For each source, a register with no pending producer supplies its register-file value, and a pending one supplies the producer's tag, whose value is taken from the bus later. Every broadcast result equals the program-order meaning of the instruction: `inOp`=0 gives srcA+srcB and `inOp`=1 gives srcA−srcB, both modulo 2^DW.
- R4: When a source's producer broadcasts in the same cycle the consumer is accepted, the consumer takes the bus value at once and never waits on that tag.
- R5: A station begins execution in the cycle after both operands are known. An instruction whose operands are known at issue broadcasts in the cycle that follows the (LAT+2)-th rising edge counted from its accepting edge, and never earlier.
- R6: At most one result is broadcast per cycle. When several stations have finished, the lowest-numbered one is broadcast and the others keep their results for later cycles.
- R7: A broadcast writes a register and clears its pending state only if that register's status still names the broadcasting tag. An older result for a register that has since been renamed leaves the register unchanged.
- R8: A station whose result is broadcast in a cycle becomes free at the next edge, so it can accept an instruction in the following cycle but not in the broadcast cycle itself.
- R9: `rdData` shows the register-file value at `rdAddr`. `rdPending` is high from the edge that renames that register until the broadcast that clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Queue head holds an instruction |
| inOp | input | 1 | 0 = add, 1 = subtract |
| inDst | input | $clog2(NREG) | Destination register |
| inSrcA | input | $clog2(NREG) | First source register |
| inSrcB | input | $clog2(NREG) | Second source register |
| inReady | output | 1 | A station is free; the head is taken when valid |
| issueTag | output | $clog2(NRS) | Station that takes the head this cycle |
| cdbValid | output | 1 | A result is on the shared bus |
| cdbTag | output | $clog2(NRS) | Station whose result is on the bus |
| cdbData | output | DW | Result value on the bus |
| rdAddr | input | $clog2(NREG) | Observation read address |
| rdData | output | DW | Register-file value at rdAddr |
| rdPending | output | 1 | A result for rdAddr is still outstanding |

## Verification
The bench targets the consumer that is accepted in the very cycle its producer broadcasts. A design without the issue-time bypass would record a tag nobody will send again, and that station would hang. It also covers two stations that wake on the same tag and finish together: a wrong arbiter would drop one result or broadcast both in one cycle. Two writes to one register in flight are checked too, where a design that ignores the status tag would let the older value overwrite the newer rename. Finally, a full pool is checked to release its station exactly one cycle after the broadcast. A sweep over every destination/source triple, followed by a pseudo-random stream, compares each broadcast against program-order arithmetic.

// File: rtl/renamePkg.sv
package renamePkg;

  // Lifecycle of one reservation station
  typedef enum logic [1:0] {
    SLOT_FREE,
    SLOT_WAIT,
    SLOT_EXEC,
    SLOT_DONE
  } slotState_t;

  // Issue-time strobes from control to datapath
  typedef struct packed {
    logic issueEn;
    logic aFromBus;
    logic bFromBus;
  } issueStrobe_t;

  // Per-station strobes from control to datapath
  typedef struct packed {
    logic capA;
    logic capB;
    logic start;
  } slotStrobe_t;

endpackage

// File: rtl/renameCtrl.sv
module renameCtrl
  import renamePkg::*;
#(
  parameter int NRS  = 4,
  parameter int NREG = 8,
  parameter int LAT  = 3,
  localparam int TAG_W = (NRS > 1) ? $clog2(NRS) : 1,
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [REG_W-1:0]         inDst,
  input  logic [REG_W-1:0]         inSrcA,
  input  logic [REG_W-1:0]         inSrcB,
  input  logic [REG_W-1:0]         rdAddr,
  output logic                     inReady,
  output logic [TAG_W-1:0]         issueTag,
  output issueStrobe_t             issStb,
  output slotStrobe_t [NRS-1:0]    slotStb,
  output logic                     cdbValid,
  output logic [TAG_W-1:0]         cdbTag,
  output logic [NREG-1:0]          regWrite,
  output logic                     rdPending
);

  logic [NRS-1:0]   freeVec;
  logic [NRS-1:0]   doneVec;
  logic             freeHit;
  logic             issueFire;
  logic [NREG-1:0]  statBusy;
  logic [TAG_W-1:0] statTag [NREG];
  logic             aPend, bPend, aBus, bBus;
  logic [TAG_W-1:0] aTag, bTag;

  // Lowest free station takes the head; lowest finished station owns the bus
  always_comb begin : pickSlots
    freeHit  = 1'b0;
    issueTag = '0;
    cdbValid = 1'b0;
    cdbTag   = '0;
    for (int i = NRS - 1; i >= 0; i--) begin
      if (freeVec[i]) begin
        freeHit  = 1'b1;
        issueTag = TAG_W'(i);
      end
      if (doneVec[i]) begin
        cdbValid = 1'b1;
        cdbTag   = TAG_W'(i);
      end
    end
  end

  assign inReady   = freeHit;
  assign issueFire = inValid && freeHit;

  // Source lookup in the status table, with same-cycle bus bypass
  always_comb begin : resolveSources
    aPend = statBusy[inSrcA];
    aTag  = statTag[inSrcA];
    bPend = statBusy[inSrcB];
    bTag  = statTag[inSrcB];
    aBus  = aPend && cdbValid && (cdbTag == aTag);
    bBus  = bPend && cdbValid && (cdbTag == bTag);
    issStb.issueEn  = issueFire;
    issStb.aFromBus = aBus;
    issStb.bFromBus = bBus;
  end

  for (genvar i = 0; i < NRS; i++) begin : gSlot
    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(i);
    slotState_t       st;
    logic             rdyA, rdyB;
    logic [TAG_W-1:0] tagA, tagB;
    logic [CNT_W-1:0] cnt;

    assign freeVec[i] = (st == SLOT_FREE);
    assign doneVec[i] = (st == SLOT_DONE);
    assign slotStb[i].capA  = (st == SLOT_WAIT) && !rdyA && cdbValid && (tagA == cdbTag);
    assign slotStb[i].capB  = (st == SLOT_WAIT) && !rdyB && cdbValid && (tagB == cdbTag);
    assign slotStb[i].start = (st == SLOT_WAIT) && rdyA && rdyB;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st   <= SLOT_FREE;
        rdyA <= 1'b0;
        rdyB <= 1'b0;
        tagA <= '0;
        tagB <= '0;
        cnt  <= '0;
      end else begin
        unique case (st)
          SLOT_FREE: begin
            if (issueFire && (issueTag == MY_TAG)) begin
              st   <= SLOT_WAIT;
              rdyA <= !aPend || aBus;
              rdyB <= !bPend || bBus;
              tagA <= aTag;
              tagB <= bTag;
            end
          end
          SLOT_WAIT: begin
            if (slotStb[i].capA) rdyA <= 1'b1;
            if (slotStb[i].capB) rdyB <= 1'b1;
            if (slotStb[i].start) begin
              st  <= SLOT_EXEC;
              cnt <= CNT_W'(LAT - 1);
            end
          end
          SLOT_EXEC: begin
            if (cnt == '0) st <= SLOT_DONE;
            else           cnt <= cnt - CNT_W'(1);
          end
          default: begin
            if (cdbTag == MY_TAG) st <= SLOT_FREE;
          end
        endcase
      end
    end
  end

  // Register status table: write only if the entry still names the bus tag
  always_comb begin : matchWrites
    for (int r = 0; r < NREG; r++) begin
      regWrite[r] = cdbValid && statBusy[r] && (statTag[r] == cdbTag);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statBusy <= '0;
      for (int r = 0; r < NREG; r++) statTag[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (issueFire && (inDst == REG_W'(r))) begin
          statBusy[r] <= 1'b1;
          statTag[r]  <= issueTag;
        end else if (regWrite[r]) begin
          statBusy[r] <= 1'b0;
        end
      end
    end
  end

  assign rdPending = statBusy[rdAddr];

endmodule

// File: rtl/renameData.sv
module renameData
  import renamePkg::*;
#(
  parameter int NRS  = 4,
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int TAG_W = (NRS > 1) ? $clog2(NRS) : 1,
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inOp,
  input  logic [REG_W-1:0]      inSrcA,
  input  logic [REG_W-1:0]      inSrcB,
  input  logic [REG_W-1:0]      rdAddr,
  input  logic [TAG_W-1:0]      issueTag,
  input  logic [TAG_W-1:0]      cdbTag,
  input  issueStrobe_t          issStb,
  input  slotStrobe_t [NRS-1:0] slotStb,
  input  logic [NREG-1:0]       regWrite,
  output logic [DW-1:0]         cdbData,
  output logic [DW-1:0]         rdData
);

  logic [DW-1:0] regFile   [NREG];
  logic [DW-1:0] resultArr [NRS];
  logic [DW-1:0] operA, operB;

  assign cdbData = resultArr[cdbTag];
  assign operA   = issStb.aFromBus ? cdbData : regFile[inSrcA];
  assign operB   = issStb.bFromBus ? cdbData : regFile[inSrcB];
  assign rdData  = regFile[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NREG; r++) regFile[r] <= DW'(r);
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (regWrite[r]) regFile[r] <= cdbData;
      end
    end
  end

  for (genvar i = 0; i < NRS; i++) begin : gSlot
    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(i);
    logic          opSub;
    logic [DW-1:0] valA, valB, res;

    assign resultArr[i] = res;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        opSub <= 1'b0;
        valA  <= '0;
        valB  <= '0;
        res   <= '0;
      end else if (issStb.issueEn && (issueTag == MY_TAG)) begin
        valA  <= operA;
        valB  <= operB;
        opSub <= inOp;
      end else begin
        if (slotStb[i].capA)  valA <= cdbData;
        if (slotStb[i].capB)  valB <= cdbData;
        if (slotStb[i].start) res  <= opSub ? (valA - valB) : (valA + valB);
      end
    end
  end

endmodule

// File: rtl/renameIssue.sv
module renameIssue
  import renamePkg::*;
#(
  parameter int NRS  = 4,
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int LAT  = 3,
  localparam int TAG_W = (NRS > 1) ? $clog2(NRS) : 1,
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inOp,
  input  logic [REG_W-1:0] inDst,
  input  logic [REG_W-1:0] inSrcA,
  input  logic [REG_W-1:0] inSrcB,
  output logic             inReady,
  output logic [TAG_W-1:0] issueTag,
  output logic             cdbValid,
  output logic [TAG_W-1:0] cdbTag,
  output logic [DW-1:0]    cdbData,
  input  logic [REG_W-1:0] rdAddr,
  output logic [DW-1:0]    rdData,
  output logic             rdPending
);

  issueStrobe_t          issStb;
  slotStrobe_t [NRS-1:0] slotStb;
  logic [NREG-1:0]       regWrite;

  renameCtrl #(.NRS(NRS), .NREG(NREG), .LAT(LAT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inDst    (inDst),
    .inSrcA   (inSrcA),
    .inSrcB   (inSrcB),
    .rdAddr   (rdAddr),
    .inReady  (inReady),
    .issueTag (issueTag),
    .issStb   (issStb),
    .slotStb  (slotStb),
    .cdbValid (cdbValid),
    .cdbTag   (cdbTag),
    .regWrite (regWrite),
    .rdPending(rdPending)
  );

  renameData #(.NRS(NRS), .NREG(NREG), .DW(DW)) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .inOp    (inOp),
    .inSrcA  (inSrcA),
    .inSrcB  (inSrcB),
    .rdAddr  (rdAddr),
    .issueTag(issueTag),
    .cdbTag  (cdbTag),
    .issStb  (issStb),
    .slotStb (slotStb),
    .regWrite(regWrite),
    .cdbData (cdbData),
    .rdData  (rdData)
  );

endmodule

// File: rtl/renameIssueChk.sv
module renameIssueChk #(
  parameter int NRS  = 4,
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int TAG_W = (NRS > 1) ? $clog2(NRS) : 1,
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic [REG_W-1:0] inDst,
  input logic [TAG_W-1:0] issueTag,
  input logic             cdbValid,
  input logic [TAG_W-1:0] cdbTag,
  input logic [REG_W-1:0] rdAddr,
  input logic [DW-1:0]    rdData,
  input logic             rdPending
);

  AST_NO_REPEAT_BROADCAST: assert property (@(posedge clk) disable iff (!rstN)
    cdbValid |=> !(cdbValid && (cdbTag == $past(cdbTag)))); // R8

  AST_NO_INSTANT_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !(cdbValid && (cdbTag == $past(issueTag)))); // R5

  AST_RENAME_MARKS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && (rdAddr == inDst)) |=> (rdPending || (rdAddr != $past(rdAddr)))); // R9

  AST_WRITE_NEEDS_BROADCAST: assert property (@(posedge clk) disable iff (!rstN)
    !cdbValid |=> ($stable(rdData) || (rdAddr != $past(rdAddr)))); // R7

endmodule

bind renameIssue renameIssueChk #(.NRS(NRS), .NREG(NREG), .DW(DW)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .inDst    (inDst),
  .issueTag (issueTag),
  .cdbValid (cdbValid),
  .cdbTag   (cdbTag),
  .rdAddr   (rdAddr),
  .rdData   (rdData),
  .rdPending(rdPending)
);

// File: tb/renameIssue_tb_top.sv
`timescale 1ns/1ps
module renameIssue_tb_top;

  localparam int NRS  = 4;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int LAT  = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          inValid, inOp;
  logic [2:0]    inDst, inSrcA, inSrcB, rdAddr;
  logic          inReady, cdbValid, rdPending;
  logic [1:0]    issueTag, cdbTag;
  logic [DW-1:0] cdbData, rdData;

  logic [DW-1:0] refReg  [NREG];
  logic [DW-1:0] expVal  [NRS];
  logic          expLive [NRS];
  int            checks = 0, fails = 0, issued = 0, seen = 0;
  logic [1:0]    slot;
  logic [DW-1:0] oldVal;
  logic [15:0]   lfsr;

  always #4 clk = ~clk;

  renameIssue #(.NRS(NRS), .NREG(NREG), .DW(DW), .LAT(LAT)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inDst(inDst),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inReady(inReady), .issueTag(issueTag),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData), .rdAddr(rdAddr),
    .rdData(rdData), .rdPending(rdPending)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Program-order reference for the instruction accepted this cycle
  task automatic record(input logic [2:0] d, input logic [2:0] a, input logic [2:0] b,
                        input logic op, output logic [1:0] s);
    s = issueTag;
    expVal[s]  = op ? (refReg[a] - refReg[b]) : (refReg[a] + refReg[b]);
    expLive[s] = 1'b1;
    refReg[d]  = expVal[s];
    issued++;
  endtask

  task automatic issueOne(input logic [2:0] d, input logic [2:0] a, input logic [2:0] b,
                          input logic op, output logic [1:0] s);
    @(negedge clk);
    inValid = 1'b1; inDst = d; inSrcA = a; inSrcB = b; inOp = op;
    while (!inReady) @(negedge clk);
    record(d, a, b, op, s);
  endtask

  task automatic stopIssue();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  task automatic checkRegs(input string req);
    for (int r = 0; r < NREG; r++) begin
      rdAddr = 3'(r);
      #0.1;
      chk(rdData == refReg[r] && !rdPending, req, {15'd0, rdPending, rdData}, {16'd0, refReg[r]});
    end
  endtask

  // Every broadcast must carry the program-order value of its station (R3, R6)
  always @(negedge clk) begin
    if (rstN === 1'b1 && cdbValid) begin
      chk(expLive[cdbTag], "R6", {30'd0, cdbTag}, 32'd0);
      chk(cdbData == expVal[cdbTag], "R3", {16'd0, cdbData}, {16'd0, expVal[cdbTag]});
      expLive[cdbTag] = 1'b0;
      seen++;
    end
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inOp = 1'b0;
    inDst = '0; inSrcA = '0; inSrcB = '0; rdAddr = '0;
    for (int r = 0; r < NREG; r++) refReg[r] = DW'(r);
    for (int s = 0; s < NRS; s++) begin expLive[s] = 1'b0; expVal[s] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(inReady && !cdbValid, "R1", {30'd0, inReady, cdbValid}, 32'h2);
    checkRegs("R1");

    // R5: single instruction latency; R2 lowest slot; R9 pending
    issueOne(3'd1, 3'd2, 3'd3, 1'b0, slot);
    chk(slot == 2'd0, "R2", {30'd0, slot}, 32'd0);
    for (int k = 1; k <= LAT + 2; k++) begin
      @(negedge clk);
      if (k == 1) begin
        inValid = 1'b0; rdAddr = 3'd1; #0.1;
        chk(rdPending, "R9", {31'd0, rdPending}, 32'd1);
      end
      if (k <= LAT + 1) chk(!cdbValid, "R5", {31'd0, cdbValid}, 32'd0);
      else chk(cdbValid && cdbTag == 2'd0, "R5", {29'd0, cdbValid, cdbTag}, 32'h4);
    end
    @(negedge clk);
    rdAddr = 3'd1; #0.1;
    chk(rdData == 16'd5 && !rdPending, "R9", {15'd0, rdPending, rdData}, 32'd5);
    drain();

    // R2 / R8: fill every station, stall, release one cycle after broadcast
    issueOne(3'd4, 3'd0, 3'd1, 1'b0, slot); chk(slot == 2'd0, "R2", {30'd0, slot}, 32'd0);
    issueOne(3'd5, 3'd1, 3'd2, 1'b0, slot); chk(slot == 2'd1, "R2", {30'd0, slot}, 32'd1);
    issueOne(3'd6, 3'd2, 3'd3, 1'b0, slot); chk(slot == 2'd2, "R2", {30'd0, slot}, 32'd2);
    issueOne(3'd7, 3'd3, 3'd0, 1'b0, slot); chk(slot == 2'd3, "R2", {30'd0, slot}, 32'd3);
    @(negedge clk);
    inDst = 3'd0; inSrcA = 3'd6; inSrcB = 3'd5; inOp = 1'b1;
    chk(!inReady, "R2", {31'd0, inReady}, 32'd0);
    @(negedge clk);
    chk(cdbValid && cdbTag == 2'd0 && !inReady, "R8", {29'd0, cdbValid, inReady, cdbTag[0]}, 32'h4);
    @(negedge clk);
    chk(inReady && issueTag == 2'd0, "R8", {29'd0, inReady, issueTag}, 32'h4);
    record(3'd0, 3'd6, 3'd5, 1'b1, slot);
    stopIssue();
    drain();
    checkRegs("R2");

    // R4: consumer accepted in the producer's broadcast cycle
    issueOne(3'd1, 3'd2, 3'd3, 1'b0, slot);
    stopIssue();
    while (!cdbValid) @(negedge clk);
    inValid = 1'b1; inDst = 3'd2; inSrcA = 3'd1; inSrcB = 3'd1; inOp = 1'b0;
    chk(inReady && issueTag == 2'd1, "R4", {29'd0, inReady, issueTag}, 32'h5);
    record(3'd2, 3'd1, 3'd1, 1'b0, slot);
    stopIssue();
    drain();
    checkRegs("R4");

    // R6: two stations finish together; lower one first, other held
    issueOne(3'd1, 3'd2, 3'd3, 1'b0, slot);
    issueOne(3'd5, 3'd1, 3'd2, 1'b0, slot);
    issueOne(3'd6, 3'd1, 3'd3, 1'b1, slot);
    stopIssue();
    while (!cdbValid) @(negedge clk);
    chk(cdbTag == 2'd0, "R6", {30'd0, cdbTag}, 32'd0);
    @(negedge clk);
    while (!cdbValid) @(negedge clk);
    chk(cdbTag == 2'd1, "R6", {30'd0, cdbTag}, 32'd1);
    @(negedge clk);
    chk(cdbValid && cdbTag == 2'd2, "R6", {29'd0, cdbValid, cdbTag}, 32'h6);
    drain();
    checkRegs("R6");

    // R7: two writes to one register in flight
    oldVal = refReg[1];
    issueOne(3'd1, 3'd4, 3'd5, 1'b0, slot);
    issueOne(3'd1, 3'd6, 3'd7, 1'b1, slot);
    stopIssue();
    while (!cdbValid) @(negedge clk);
    @(negedge clk);
    rdAddr = 3'd1; #0.1;
    chk(rdData == oldVal && rdPending, "R7", {15'd0, rdPending, rdData}, {15'd0, 1'b1, oldVal});
    @(negedge clk);
    rdAddr = 3'd1; #0.1;
    chk(rdData == refReg[1] && !rdPending, "R7", {15'd0, rdPending, rdData}, {16'd0, refReg[1]});
    drain();

    // R3: every destination/source triple, then a pseudo-random stream
    for (int d = 0; d < NREG; d++)
      for (int a = 0; a < NREG; a++)
        for (int b = 0; b < NREG; b++)
          issueOne(3'(d), 3'(a), 3'(b), 1'(d ^ a ^ b), slot);
    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issueOne(lfsr[2:0], lfsr[5:3], lfsr[8:6], lfsr[9], slot);
    end
    stopIssue();
    drain();
    checkRegs("R3");
    chk(seen == issued, "R3", 32'(seen), 32'(issued));
    for (int s = 0; s < NRS; s++) chk(!expLive[s], "R3", {31'd0, expLive[s]}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule